// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave Front End

This block is the slave side of the serial link for a small nonvolatile byte memory with a 2048-byte array. A host frames every command with an active-low select. It shifts opcode, address and data bits in on one line and receives read data on another. The block runs on its own system clock. It synchronises select, serial clock and input data, then detects their edges, so the serial clock must be several times slower than the system clock. Both serial modes with rising-edge sampling are accepted: idle-low (mode 0) and idle-high (mode 3).

Write data collects in a 32-byte page buffer. It is committed only when select rises after a complete write sequence that ends on a byte boundary. The commit then runs as a timed internal cycle that copies the loaded bytes into a synchronous array model, one byte per clock, and holds a busy flag. A separate protection/status block is reached through a small side port. This block exposes the current address to it and obeys a deny input at commit time. It also forwards status-register writes and shows six status bits that come from that block.

Top module: `spi_ee_slave`

## Requirements
- R1: Input bits are taken MSB first on rising edges of the serial clock while selected. A READ or WRITE opcode is followed by 16 address bits; only the low 11 are used and the upper 5 are ignored.
- R2: The output data line changes only after falling edges of the serial clock. The MSB of the first read byte is presented after the falling edge that follows the last address bit, in both mode 0 and mode 3.
- R3: `spi_so_oe` is 0 while select is high and 1 while select is low.
- R4: READ (0x03) returns consecutive bytes from increasing addresses, and the address wraps from 0x7FF to 0x000.
- R5: WREN (0x06) sets the write-enable latch and WRDI (0x04) clears it. WRITE (0x02) and WRSR (0x01) are ignored while the latch is 0. The latch clears when a commit starts.
- R6: RDSR (0x05) returns the byte {prot_status[5:0], write-enable latch, busy}, from bit 7 down to bit 0, repeated for as long as clocks arrive.
- R7: WRITE data fills a 32-byte page buffer. The offset wraps within the page (the low 5 address bits). A commit happens only when select rises after at least one full data byte, on a byte boundary; otherwise nothing is written.
- R8: A commit holds `busy` high for exactly WRITE_CYCLES clocks and writes only the page bytes that were loaded.
- R9: While `busy` is high, every opcode except RDSR is ignored.
- R10: If `prot_deny` is high when select rises after a valid write, the page is discarded, `busy` stays low and the write-enable latch keeps its value.
- R11: WRSR, with the write-enable latch set and ending on a byte boundary, gives a one-clock `sr_wr_valid` pulse carrying the last data byte and starts a busy cycle.
- R12: An unknown opcode makes the block ignore every following bit until select rises.
- R13: After reset, `busy`, `spi_so_oe` and the write-enable latch are 0. Each command starts at a falling edge of select, and a command cut short by select rising leaves no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sck | input | 1 | Serial clock from the host |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data toward the host |
| spi_so_oe | output | 1 | Output enable for spi_so (0 means high impedance) |
| prot_addr | output | 11 | Current command address, offered to the protection block |
| prot_deny | input | 1 | Protection block refuses the pending page write |
| prot_status | input | 6 | Status bits 7..2 owned by the protection block |
| sr_wr_valid | output | 1 | One-clock request to write the status register |
| sr_wr_data | output | 8 | Status byte carried by sr_wr_valid |
| busy | output | 1 | Internal write cycle running |

## Verification
Assertions check on every cycle that the output bit moves only after a detected falling serial-clock edge. They also check that no commit starts while busy, that the page buffer never loads and the array is never written outside the permitted busy window, that a commit drops the write-enable latch, and that the status request is a single-clock pulse. The data values themselves can only be shown by the bench's scenarios. These are: array contents after page wrap and read wrap, ignored upper address bits, rejection of partial or unlatched writes, the deny path, the exact busy length, and readout in mode 3.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
   typedef enum logic [2:0] {
      PH_OPC, PH_AHI, PH_ALO, PH_RD, PH_RDSR, PH_WDAT, PH_SDAT, PH_IGN
   } phase_t;

   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_WRITE = 8'h02;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRDI = 8'h04;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_WRSR = 8'h01;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_ee_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/spi_ee_commit.sv
module spi_ee_commit #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 5,
   parameter int WRITE_CYCLES = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_clr,
   input  logic                     load_en,
   input  logic [PAGE_W-1:0]        load_off,
   input  logic [7:0]               load_data,
   input  logic                     page_start,
   input  logic                     sr_start,
   input  logic [ADDR_W-PAGE_W-1:0] page_base,
   output logic                     busy,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_waddr,
   output logic [7:0]               mem_wdata
);
   localparam int DEPTH = 1 << PAGE_W;
   localparam int CW = $clog2(WRITE_CYCLES + 1);

   generate
      if (WRITE_CYCLES < DEPTH) begin : g_bad_cycles
         $error("spi_ee_commit: WRITE_CYCLES must cover one clock per page byte");
      end
   endgenerate

   logic [7:0]              pbuf [DEPTH];
   logic [DEPTH-1:0]        mask;
   logic [CW-1:0]           cnt;
   logic [PAGE_W-1:0]       wi;
   logic                    active;
   logic [ADDR_W-PAGE_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (load_en) pbuf[load_off] <= load_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask   <= '0;
         cnt    <= '0;
         wi     <= '0;
         active <= 1'b0;
         base_q <= '0;
      end else begin
         if (load_clr)     mask <= '0;
         else if (load_en) mask[load_off] <= 1'b1;

         if (page_start || sr_start) cnt <= CW'(WRITE_CYCLES);
         else if (cnt != '0)         cnt <= cnt - 1'b1;

         if (page_start) begin
            active <= 1'b1;
            wi     <= '0;
            base_q <= page_base;
         end else if (active) begin
            if (wi == PAGE_W'(DEPTH - 1)) active <= 1'b0;
            wi <= wi + 1'b1;
         end
      end
   end

   assign busy      = (cnt != '0);
   assign mem_we    = active && mask[wi];
   assign mem_waddr = {base_q, wi};
   assign mem_wdata = pbuf[wi];

   // R8: the array is written only inside the busy window
   a_r8_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);
   // R9: the page buffer is never loaded while a commit runs
   a_r9_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> !busy);
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 5,
   parameter int WRITE_CYCLES = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_si,
   output logic              spi_so,
   output logic              spi_so_oe,
   output logic [ADDR_W-1:0] prot_addr,
   input  logic              prot_deny,
   input  logic [5:0]        prot_status,
   output logic              sr_wr_valid,
   output logic [7:0]        sr_wr_data,
   output logic              busy
);
   localparam int PB_W = ADDR_W - PAGE_W;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("spi_ee_slave: ADDR_W must lie in 9..16");
      end
      if (PAGE_W < 1 || PAGE_W > 8 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("spi_ee_slave: PAGE_W must lie in 1..8 and below ADDR_W");
      end
   endgenerate

   // synchronised pins: {cs_n, sck, si}
   logic [2:0] pins_s;
   logic       cs_s, sck_s, si_s, cs_q, sck_q;

   spi_ee_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({spi_cs_n, spi_sck, spi_si}), .q(pins_s));

   assign {cs_s, sck_s, si_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= cs_s;
         sck_q <= sck_s;
      end
   end

   logic cs_fall, cs_rise, sck_rise, sck_fall;
   assign cs_fall  = cs_q && !cs_s;
   assign cs_rise  = !cs_q && cs_s;
   assign sck_rise = !sck_q && sck_s && !cs_s;
   assign sck_fall = sck_q && !sck_s && !cs_s;

   phase_t            ph;
   logic [2:0]        b;
   logic [6:0]        sh;
   logic [7:0]        byte_in, status, cur_byte, sr_byte, mem_rdata;
   logic [ADDR_W-1:0] addr;
   logic [PAGE_W-1:0] woff;
   logic              is_rd, wel, got_data, page_start, sr_start;
   logic              rd_req, rd_pend, so_q;
   logic              load_en, load_clr, mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [7:0]        mem_wdata;

   assign byte_in  = {sh, si_s};
   assign status   = {prot_status, wel, busy};
   assign load_en  = sck_rise && (b == 3'd7) && (ph == PH_WDAT);
   assign load_clr = sck_rise && (b == 3'd7) && (ph == PH_ALO) && !is_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_IGN;    b <= '0;        sh <= '0;         addr <= '0;
         woff <= '0;      is_rd <= 1'b0;  wel <= 1'b0;      got_data <= 1'b0;
         sr_byte <= '0;   page_start <= 1'b0; sr_start <= 1'b0;
         rd_req <= 1'b0;  rd_pend <= 1'b0; cur_byte <= '0;  so_q <= 1'b0;
      end else begin
         page_start <= 1'b0;
         sr_start   <= 1'b0;
         rd_req     <= 1'b0;
         rd_pend    <= rd_req;
         if (rd_pend) cur_byte <= mem_rdata;

         if (cs_fall) begin
            ph       <= PH_OPC;
            b        <= '0;
            got_data <= 1'b0;
         end else if (cs_rise) begin
            if (ph == PH_WDAT && got_data && b == 3'd0 && !prot_deny) begin
               page_start <= 1'b1;
               wel        <= 1'b0;
            end
            if (ph == PH_SDAT && got_data && b == 3'd0) begin
               sr_start <= 1'b1;
               wel      <= 1'b0;
            end
            ph <= PH_IGN;
         end else if (sck_rise) begin
            sh <= byte_in[6:0];
            b  <= b + 3'd1;
            if (b == 3'd7) begin
               case (ph)
                  PH_OPC: begin
                     if (busy && byte_in != OP_RDSR) ph <= PH_IGN;
                     else begin
                        case (byte_in)
                           OP_READ:  begin is_rd <= 1'b1; ph <= PH_AHI; end
                           OP_WRITE: begin is_rd <= 1'b0; ph <= wel ? PH_AHI : PH_IGN; end
                           OP_WREN:  begin wel <= 1'b1; ph <= PH_IGN; end
                           OP_WRDI:  begin wel <= 1'b0; ph <= PH_IGN; end
                           OP_RDSR:  ph <= PH_RDSR;
                           OP_WRSR:  ph <= wel ? PH_SDAT : PH_IGN;
                           default:  ph <= PH_IGN;
                        endcase
                     end
                  end
                  PH_AHI: begin
                     addr[ADDR_W-1:8] <= byte_in[ADDR_W-9:0];
                     ph <= PH_ALO;
                  end
                  PH_ALO: begin
                     addr[7:0] <= byte_in;
                     if (is_rd) begin
                        rd_req <= 1'b1;
                        ph     <= PH_RD;
                     end else begin
                        woff <= byte_in[PAGE_W-1:0];
                        ph   <= PH_WDAT;
                     end
                  end
                  PH_WDAT: begin
                     woff     <= woff + 1'b1;
                     got_data <= 1'b1;
                  end
                  PH_SDAT: begin
                     sr_byte  <= byte_in;
                     got_data <= 1'b1;
                  end
                  default: ;
               endcase
            end
         end else if (sck_fall) begin
            if (ph == PH_RD) begin
               so_q <= cur_byte[3'd7 - b];
               if (b == 3'd7) begin
                  addr   <= addr + 1'b1;
                  rd_req <= 1'b1;
               end
            end else if (ph == PH_RDSR) begin
               so_q <= status[3'd7 - b];
            end
         end
      end
   end

   spi_ee_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_commit (
      .clk(clk), .rst_n(rst_n), .load_clr(load_clr), .load_en(load_en),
      .load_off(woff), .load_data(byte_in), .page_start(page_start), .sr_start(sr_start),
      .page_base(addr[ADDR_W-1:PAGE_W]), .busy(busy), .mem_we(mem_we),
      .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

   spi_ee_array #(.ADDR_W(ADDR_W)) u_array (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .re(rd_req), .raddr(addr), .rdata(mem_rdata));

   assign spi_so      = so_q;
   assign spi_so_oe   = !cs_s;
   assign prot_addr   = addr;
   assign sr_wr_valid = sr_start;
   assign sr_wr_data  = sr_byte;

   // R2: the output bit moves only after a falling serial-clock edge
   a_r2_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(so_q) |-> $past(sck_fall));
   // R9: no commit is launched while the previous one still runs
   a_r9_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (page_start || sr_start) |-> !busy);
   // R5: a commit leaves the write-enable latch cleared
   a_r5_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (page_start || sr_start) |=> !wel);
   // R8: the busy flag follows a page commit
   a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      page_start |=> busy);
   // R11: the status write request lasts one clock
   a_r11_sr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sr_wr_valid |=> !sr_wr_valid);
endmodule

// File: tb/spi_ee_slave_test.sv
module spi_ee_slave_test;
   localparam int WCYC = 2000;
   localparam int H = 8;
   localparam logic [23:0] VEC [6] = '{
      24'h0010A5, 24'h07FF3C, 24'hF80596, 24'h040000, 24'h0123FF, 24'h00005A
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic        so, so_oe, prot_deny = 1'b0, sr_v, busy;
   logic [10:0] p_addr;
   logic [5:0]  p_stat = 6'b101101;
   logic [7:0]  sr_d;
   logic        mode3 = 1'b0;
   logic        done = 1'b0;
   int          n_chk = 0, n_fail = 0;
   int          run = 0, last_run = 0, sr_cnt = 0;
   logic [7:0]  sr_last = '0;

   always #2 clk = ~clk;

   spi_ee_slave #(.WRITE_CYCLES(WCYC)) uut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
      .spi_so(so), .spi_so_oe(so_oe), .prot_addr(p_addr), .prot_deny(prot_deny),
      .prot_status(p_stat), .sr_wr_valid(sr_v), .sr_wr_data(sr_d), .busy(busy));

   always @(posedge clk) begin
      if (busy) run <= run + 1;
      else if (run != 0) begin last_run <= run; run <= 0; end
      if (sr_v) begin sr_cnt <= sr_cnt + 1; sr_last <= sr_d; end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic t, output logic r);
      sck = 1'b0; si = t;
      wait_clk(H);
      r = so;
      sck = 1'b1;
      wait_clk(H);
   endtask

   task automatic byte_x(input logic [7:0] t, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) bit_x(t[i], r[i]);
   endtask

   task automatic cs_on;
      sck = mode3; wait_clk(H);
      cs_n = 1'b0; wait_clk(H);
   endtask

   task automatic cs_off;
      sck = mode3; wait_clk(H);
      cs_n = 1'b1; wait_clk(2 * H);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] r;
      cs_on; byte_x(op, r); cs_off;
   endtask

   task automatic wait_idle;
      int g = 0;
      wait_clk(10);
      while (busy && g < 3 * WCYC) begin wait_clk(1); g++; end
   endtask

   task automatic write1(input logic [15:0] a, input logic [7:0] d, input bit wait_done);
      logic [7:0] r;
      cs_on; byte_x(8'h02, r); byte_x(a[15:8], r); byte_x(a[7:0], r); byte_x(d, r); cs_off;
      if (wait_done) wait_idle;
   endtask

   task automatic read2(input logic [15:0] a, output logic [7:0] d0, output logic [7:0] d1);
      logic [7:0] r;
      cs_on; byte_x(8'h03, r); byte_x(a[15:8], r); byte_x(a[7:0], r);
      byte_x(8'h00, d0); byte_x(8'h00, d1); cs_off;
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] r;
      cs_on; byte_x(8'h05, r); byte_x(8'h00, s); cs_off;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d0, d1, s, r;
      logic       rb;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R13 / R3: reset state
      chk("R13 busy after reset", busy, 0);
      chk("R3 so_oe deselected", so_oe, 0);
      rdsr(s);
      chk("R6 status after reset", s, 8'hB4);

      // R1 / R7: vector table, write then read back at masked address
      for (int i = 0; i < 6; i++) begin
         cmd1(8'h06);
         write1(VEC[i][23:8], VEC[i][7:0], 1'b1);
         read2({5'b0, VEC[i][18:8]}, d0, d1);
         chk($sformatf("R1 vector %0d readback", i), d0, VEC[i][7:0]);
      end

      // R4: read wraps from the top of the array
      read2(16'h07FF, d0, d1);
      chk("R4 read at top", d0, 8'h3C);
      chk("R4 read wrap to zero", d1, 8'h5A);

      // R3: output enable follows select
      cs_on;
      chk("R3 so_oe selected", so_oe, 1);
      byte_x(8'h05, r);
      cs_off;
      chk("R3 so_oe released", so_oe, 0);

      // R5 / R6: latch set and clear
      cmd1(8'h06); rdsr(s);
      chk("R5 WREN sets latch", s, 8'hB6);
      cmd1(8'h04); rdsr(s);
      chk("R5 WRDI clears latch", s, 8'hB4);
      write1(16'h0010, 8'h11, 1'b1);
      read2(16'h0010, d0, d1);
      chk("R5 write without latch ignored", d0, 8'hA5);

      // R7: page offset wraps within the page
      cmd1(8'h06);
      cs_on; byte_x(8'h02, r); byte_x(8'h00, r); byte_x(8'h3F, r);
      byte_x(8'h11, r); byte_x(8'h22, r); cs_off; wait_idle;
      read2(16'h003F, d0, d1);
      chk("R7 page last byte", d0, 8'h11);
      read2(16'h0020, d0, d1);
      chk("R7 page wrap byte", d0, 8'h22);

      // R7: partial byte and no-data writes commit nothing
      cmd1(8'h06); write1(16'h0050, 8'h44, 1'b1);
      cmd1(8'h06);
      cs_on; byte_x(8'h02, r); byte_x(8'h00, r); byte_x(8'h50, r); byte_x(8'h77, r);
      for (int k = 0; k < 3; k++) bit_x(1'b1, rb);
      cs_off; wait_clk(20);
      chk("R7 partial write no busy", busy, 0);
      cs_on; byte_x(8'h02, r); byte_x(8'h00, r); byte_x(8'h50, r); cs_off; wait_clk(20);
      chk("R7 no-data write no busy", busy, 0);
      read2(16'h0050, d0, d1);
      chk("R7 partial write left data", d0, 8'h44);

      // R8 / R9: busy window
      cmd1(8'h06);
      write1(16'h0060, 8'h12, 1'b0);
      rdsr(s);
      chk("R8 status while busy", s, 8'hB5);
      cmd1(8'h06);
      wait_idle;
      rdsr(s);
      chk("R9 WREN ignored while busy", s, 8'hB4);
      chk("R8 busy length", last_run, WCYC);
      read2(16'h0060, d0, d1);
      chk("R8 committed byte", d0, 8'h12);

      // R10: deny discards the page
      cmd1(8'h06); write1(16'h0070, 8'h33, 1'b1);
      cmd1(8'h06);
      prot_deny = 1'b1;
      write1(16'h0070, 8'hEE, 1'b0);
      wait_clk(20);
      chk("R10 denied no busy", busy, 0);
      prot_deny = 1'b0;
      read2(16'h0070, d0, d1);
      chk("R10 denied data kept", d0, 8'h33);
      rdsr(s);
      chk("R10 latch kept", s, 8'hB6);

      // R11: status register write request
      cs_on; byte_x(8'h01, r); byte_x(8'hC8, r); cs_off; wait_clk(10);
      chk("R11 request count", sr_cnt, 1);
      chk("R11 request data", sr_last, 8'hC8);
      wait_idle;
      rdsr(s);
      chk("R11 latch cleared", s, 8'hB4);
      cs_on; byte_x(8'h01, r); byte_x(8'h55, r); cs_off; wait_clk(10);
      chk("R11 no request without latch", sr_cnt, 1);

      // R12: unknown opcode swallows the rest
      cmd1(8'h06);
      cs_on; byte_x(8'hAB, r); byte_x(8'h02, r); byte_x(8'h00, r); byte_x(8'h50, r);
      byte_x(8'h99, r); cs_off; wait_clk(20);
      chk("R12 unknown no busy", busy, 0);
      read2(16'h0050, d0, d1);
      chk("R12 unknown no write", d0, 8'h44);

      // R2: mode 3 readout
      mode3 = 1'b1;
      read2(16'h0010, d0, d1);
      chk("R2 mode3 read", d0, 8'hA5);
      rdsr(s);
      chk("R2 mode3 status", s, 8'hB6);
      mode3 = 1'b0;
      wait_clk(2 * H);

      // R13: a cut-short command has no effect, next one starts cleanly
      cs_on; for (int k = 0; k < 3; k++) bit_x(1'b0, rb); cs_off;
      rdsr(s);
      chk("R13 restart after abort", s, 8'hB6);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule